// File: doc/BRIEF.md
# Protected Register Unlock Sequencer

This block guards the write enable of a chip's protected control bits. Software opens them by writing a fixed three-byte key to one protection register. The bytes must arrive in order, and no other bus access may fall between them. Once the last byte lands, the block holds an unlocked state until a write to the protection register that is not a key step closes it again.

Bus decoding sits outside the block. A decoder hands it a write strobe with the byte written to the protection register, and one strobe that marks any other bus access. The block returns the lock state as read data. It also gates a write request for the protected bits into a write enable that is only open while unlocked.

Top module: `prot_unlock_seq`

## Requirements
- R1: Writes of 0x59, then 0x16, then 0x88 on three key-write strobes set the unlocked state at the clock edge that samples the third write. Idle cycles between the writes do not break the sequence.
- R2: `rd_data_o` equals 1 while unlocked and 0 while locked. Bits above bit 0 are always zero.
- R3: An `other_acc_i` strobe returns the sequencer to its first step. If a key write arrives in the same cycle as `other_acc_i`, that key write is discarded.
- R4: `prot_wr_en_o` follows `prot_wr_i` in the same cycle while unlocked and stays 0 while locked.
- R5: A key write that does not match the expected byte returns the sequencer to its first step. If that byte is 0x59, it counts as a correct first key, and the sequencer moves to its second step.
- R6: When `rst_ni` is low, the block is locked and the sequencer is at its first step.
- R7: While unlocked, a key write that leaves the sequencer at its first step without completing the key locks the block at that clock edge.
- R8: While unlocked, other accesses and key writes that advance or restart the sequence leave the block unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_wr_i | input | 1 | Write strobe to the protection register |
| key_data_i | input | 8 | Byte written to the protection register |
| other_acc_i | input | 1 | Strobe for any other bus access |
| prot_wr_i | input | 1 | Write request to protected bits |
| rd_data_o | output | 8 | Read value of the protection register |
| prot_wr_en_o | output | 1 | Qualified write enable for protected bits |

## Verification
The checker takes both strobes to be one-cycle pulses, synchronous to `clk_i`, with `key_data_i` stable while `key_wr_i` is high. It also allows a key write and an other-access strobe in the same cycle, because the block defines that case. The bench changes every input only on falling edges and holds each strobe for exactly one cycle. It reaches the coincident case deliberately, both at the first step and in the middle of a sequence.

// File: rtl/unlock_pkg.sv
package unlock_pkg;
  localparam int unsigned KEY_W    = 8;
  localparam int unsigned NUM_KEYS = 3;
  typedef logic [NUM_KEYS-1:0][KEY_W-1:0] key_set_t;
  // index 0 is the first byte expected
  localparam key_set_t DEF_KEYS = {8'h88, 8'h16, 8'h59};
endpackage

// File: rtl/key_cmp.sv
module key_cmp #(
  parameter int unsigned KEY_W    = 8,
  parameter int unsigned NUM_KEYS = 3,
  parameter logic [NUM_KEYS-1:0][KEY_W-1:0] KEYS = '0
) (
  input  logic [KEY_W-1:0]    data_i,
  output logic [NUM_KEYS-1:0] hit_o
);
  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_cmp
    assign hit_o[k] = (data_i == KEYS[k]);
  end
endmodule

// File: rtl/seq_step.sv
module seq_step #(
  parameter int unsigned NUM_KEYS = 3,
  localparam int unsigned STEP_W  = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic                abort_i,
  input  logic [NUM_KEYS-1:0] hit_i,
  output logic                done_o,
  output logic                miss_o
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(NUM_KEYS - 1);

  logic [STEP_W-1:0] step_q, step_d;
  logic              hit_cur;

  assign hit_cur = hit_i[step_q];

  always_comb begin
    step_d = step_q;
    done_o = 1'b0;
    miss_o = 1'b0;
    if (abort_i) begin
      step_d = '0;
    end else if (wr_i) begin
      if (hit_cur) begin
        if (step_q == LAST) begin
          step_d = '0;
          done_o = 1'b1;
        end else begin
          step_d = step_q + 1'b1;
        end
      end else if (hit_i[0]) begin
        step_d = STEP_W'(1);  // wrong byte that is itself the first key
      end else begin
        step_d = '0;
        miss_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= '0;
    else         step_q <= step_d;
  end
endmodule

// File: rtl/lock_flag.sv
module lock_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic open_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    open_o <= 1'b0;
    else if (set_i) open_o <= 1'b1;
    else if (clr_i) open_o <= 1'b0;
  end
endmodule

// File: rtl/prot_unlock_seq.sv
module prot_unlock_seq #(
  parameter int unsigned KEY_W    = unlock_pkg::KEY_W,
  parameter int unsigned NUM_KEYS = unlock_pkg::NUM_KEYS,
  parameter logic [NUM_KEYS-1:0][KEY_W-1:0] KEYS = unlock_pkg::DEF_KEYS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             key_wr_i,
  input  logic [KEY_W-1:0] key_data_i,
  input  logic             other_acc_i,
  input  logic             prot_wr_i,
  output logic [KEY_W-1:0] rd_data_o,
  output logic             prot_wr_en_o
);
  logic [NUM_KEYS-1:0] hit;
  logic done, miss, open_q;

  key_cmp #(.KEY_W(KEY_W), .NUM_KEYS(NUM_KEYS), .KEYS(KEYS)) u_cmp (
    .data_i (key_data_i),
    .hit_o  (hit)
  );

  seq_step #(.NUM_KEYS(NUM_KEYS)) u_step (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (key_wr_i),
    .abort_i (other_acc_i),
    .hit_i   (hit),
    .done_o  (done),
    .miss_o  (miss)
  );

  lock_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (done),
    .clr_i  (miss),
    .open_o (open_q)
  );

  assign rd_data_o    = {{(KEY_W-1){1'b0}}, open_q};
  assign prot_wr_en_o = prot_wr_i & open_q;
endmodule

// File: rtl/prot_unlock_chk.sv
module prot_unlock_chk #(
  parameter int unsigned KEY_W    = 8,
  parameter int unsigned NUM_KEYS = 3,
  parameter logic [NUM_KEYS-1:0][KEY_W-1:0] KEYS = '0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             key_wr_i,
  input logic [KEY_W-1:0] key_data_i,
  input logic             other_acc_i,
  input logic             prot_wr_i,
  input logic [KEY_W-1:0] rd_data_o,
  input logic             prot_wr_en_o
);
  logic unl, any_key;
  assign unl = rd_data_o[0];
  always_comb begin
    any_key = 1'b0;
    for (int k = 0; k < NUM_KEYS; k++) any_key |= (key_data_i == KEYS[k]);
  end

  // R1
  unlock_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unl) |-> ($past(key_wr_i) && !$past(other_acc_i) &&
                    $past(key_data_i) == KEYS[NUM_KEYS-1]));
  // R2
  rd_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[KEY_W-1:1] == '0);
  // R3
  abort_keeps_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (other_acc_i && !unl) |=> !unl);
  // R4
  locked_no_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unl |-> !prot_wr_en_o);
  // R7
  bad_byte_relock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unl && key_wr_i && !other_acc_i && !any_key) |=> !unl);
  // R8
  idle_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unl && !key_wr_i) |=> unl);
endmodule

bind prot_unlock_seq prot_unlock_chk #(
  .KEY_W(KEY_W), .NUM_KEYS(NUM_KEYS), .KEYS(KEYS)
) u_chk (.*);

// File: tb/sim_prot_unlock_seq.sv
`timescale 1ns/1ps
module sim_prot_unlock_seq;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       key_wr = 1'b0;
  logic [7:0] key_data = '0;
  logic       other_acc = 1'b0;
  logic       prot_wr = 1'b0;
  logic [7:0] rd_data;
  logic       prot_wr_en;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [7:0] rd;
    logic       en;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  prot_unlock_seq u0 (
    .clk_i(clk), .rst_ni(rst_ni), .key_wr_i(key_wr), .key_data_i(key_data),
    .other_acc_i(other_acc), .prot_wr_i(prot_wr),
    .rd_data_o(rd_data), .prot_wr_en_o(prot_wr_en)
  );

  task automatic cmp(input logic [7:0] rd, input logic en, input string tag);
    checks++;
    if (rd !== rd_data || en !== prot_wr_en) begin
      failures++;
      $display("FAIL %s rd=%h exp=%h en=%b exp=%b", tag, rd_data, rd, prot_wr_en, en);
    end
  endtask

  // driver: one bus cycle, expected state after the next rising edge
  task automatic op(input logic wr, input logic [7:0] d, input logic oth,
                    input logic pw, input logic exp_unl, input string tag);
    exp_t e;
    @(negedge clk);
    key_wr = wr; key_data = d; other_acc = oth; prot_wr = pw;
    e.rd = {7'b0, exp_unl};
    e.en = pw & exp_unl;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    key_wr = 1'b0; other_acc = 1'b0; prot_wr = 1'b0; key_data = '0;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        cmp(e.rd, e.en, e.tag);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1;
    cmp(8'h00, 1'b0, "R6 reset");
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;

    // R1 basic unlock, R4 enable
    op(1, 8'h59, 0, 0, 0, "R1 k0");
    op(1, 8'h16, 0, 0, 0, "R1 k1");
    op(1, 8'h88, 0, 1, 1, "R1 R2 k2");
    op(0, 8'h00, 0, 1, 1, "R4 open");
    // R7 relock
    op(1, 8'h00, 0, 0, 0, "R7 relock");
    op(0, 8'h00, 0, 1, 0, "R4 locked");
    // R3 interrupted sequence
    op(1, 8'h59, 0, 0, 0, "R3 k0");
    op(0, 8'h00, 1, 0, 0, "R3 other");
    op(1, 8'h16, 0, 0, 0, "R3 k1");
    op(1, 8'h88, 0, 0, 0, "R3 k2");
    // R5 wrong byte 0x59 restarts
    op(1, 8'h59, 0, 0, 0, "R5 k0");
    op(1, 8'h16, 0, 0, 0, "R5 k1");
    op(1, 8'h59, 0, 0, 0, "R5 restart");
    op(1, 8'h16, 0, 0, 0, "R5 k1b");
    op(1, 8'h88, 0, 0, 1, "R5 unlock");
    // R8 unlocked holds
    op(0, 8'h00, 1, 0, 1, "R8 other");
    op(1, 8'h59, 0, 0, 1, "R8 k0");
    op(1, 8'h16, 0, 0, 1, "R8 k1");
    op(1, 8'h88, 0, 1, 1, "R8 k2");
    op(1, 8'h59, 0, 0, 1, "R8 k0b");
    op(1, 8'h59, 0, 0, 1, "R8 restart");
    op(1, 8'h42, 0, 0, 0, "R7 bad");
    // R5 wrong byte mid-sequence
    op(1, 8'h59, 0, 0, 0, "R5 w0");
    op(1, 8'h16, 0, 0, 0, "R5 w1");
    op(1, 8'h17, 0, 0, 0, "R5 wrong");
    op(1, 8'h88, 0, 1, 0, "R5 R4 noopen");
    // R3 coincident strobes
    op(1, 8'h59, 0, 0, 0, "R3 c0");
    op(1, 8'h16, 1, 0, 0, "R3 coinc");
    op(1, 8'h88, 0, 0, 0, "R3 c2");
    op(1, 8'h59, 1, 0, 0, "R3 coinc0");
    op(1, 8'h16, 0, 0, 0, "R3 c1b");
    op(1, 8'h88, 0, 0, 0, "R3 c2b");
    // R6 reset mid-state
    op(1, 8'h59, 0, 0, 0, "R6 k0");
    op(1, 8'h16, 0, 0, 0, "R6 k1");
    op(1, 8'h88, 0, 0, 1, "R6 open");
    op(1, 8'h59, 0, 0, 1, "R6 k0b");
    idle();
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    cmp(8'h00, 1'b0, "R6 async");
    @(negedge clk);
    rst_ni = 1'b1;
    op(1, 8'h16, 0, 0, 0, "R6 step0");
    op(1, 8'h88, 0, 0, 0, "R6 step0b");
    idle();
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule